// File: doc/BRIEF.md
# Write-Enable Latch with Clock-Count Guard

This block sits between the instruction decoder and the write sequencer of a serial non-volatile memory. It decides whether a decoded write-class instruction may be committed. It holds the write-enable latch. The arm command sets the latch and the disarm command clears it. Reset clears it, and so does a low-supply indication.

While chip select is high, the block counts the rising serial-clock edges of the frame. Counting starts at the start bit, which is the first edge that samples a high data bit, and that edge is counted. Edges that arrive before the start bit with a low data bit are filler edges and are not counted. When chip select falls, the block checks three things:
- the count matches the exact length the pending instruction needs;
- the latch is set;
- no low-supply indication arrived during the frame.

If all three hold, it issues a one-cycle commit pulse to the write sequencer. If any of them fails, it issues a one-cycle cancel pulse, and the sequencer stays idle. Because only an exact count is accepted, a noise edge or a lost edge cancels the instruction and leaves memory untouched.

Serial-clock edges reach the block as a one-cycle strobe `skRise` in the system clock domain. The decoder presents the decoded command on `cmdIn` and holds it until chip select has fallen. The low-supply flag arrives already filtered, with hysteresis applied outside the block.

Top module: `wel_guard`

## Requirements
- R1: After reset `writeEnabled` is 0. A write-class command (`cmdIn` 2 = word write, 3 = word erase, 4 = fill all, 5 = wipe all) whose frame ends while the latch is clear produces a cancel pulse and no commit pulse.
- R2: An arm command (`cmdIn` 6) sets the latch, and a disarm command (`cmdIn` 7) clears it. Either takes effect when chip select falls after at least CTL_LEN (13) counted edges, and `writeEnabled` shows the new value one cycle after chip select is sampled low.
- R3: An arm or disarm frame that ends with fewer than CTL_LEN counted edges leaves the latch unchanged.
- R4: Word write (2) and fill all (4) commit only when exactly LONG_LEN (29) edges were counted. A count of 28, 30 or more produces a cancel pulse instead.
- R5: Word erase (3) and wipe all (5) commit only when exactly SHORT_LEN (13) edges were counted. Any other count produces a cancel pulse.
- R6: Counting includes the start bit and every later rising edge while chip select is high. Edges with a low data bit before the start bit are not counted. Edges while chip select is low are ignored.
- R7: While `lowSupply` is high, the latch is cleared, and `writeEnabled` reads 0 in the following cycle. A write-class frame during which `lowSupply` was high is cancelled.
- R8: After a low-supply event, write-class commands are cancelled until a new arm command has completed.
- R9: Commands other than write-class (`cmdIn` 0 = none, 1 = read) never produce a commit or cancel pulse and do not change the latch.
- R10: Commit and cancel are mutually exclusive pulses, each one system clock wide. They are asserted in the cycle after the clock edge at which chip select is first sampled low. The edge counter saturates, so overlong frames never wrap back to a matching count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select level, high during a frame |
| skRise | input | 1 | One-cycle strobe marking a serial-clock rising edge |
| diIn | input | 1 | Serial data bit sampled with `skRise` |
| cmdIn | input | 3 | Decoded command, held until chip select falls |
| lowSupply | input | 1 | Filtered low-supply indication |
| commitWrite | output | 1 | Pulse: write-class command accepted |
| cancelWrite | output | 1 | Pulse: write-class command rejected |
| writeEnabled | output | 1 | Current state of the write-enable latch |

## Verification
The bench targets the off-by-one frames: 12 and 14 edges for erase, 28 and 30 edges for write. A guard that compared with greater-or-equal, or that counted the start bit inconsistently, would commit one of these corrupted frames. It also sends:
- a frame of 61 edges, which a wrapping counter would see as a match;
- filler edges before the start bit and stray edges with chip select low, either of which would wrongly lengthen a correct frame if counted.

A brief low-supply pulse in the middle of an armed write must cancel that frame and disarm the latch. A design that sampled the flag only at chip-select fall would commit the frame. A design that restored the latch afterwards would let the next write through without a fresh arm command.

// File: rtl/wel_pkg.sv
package wel_pkg;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_READ   = 3'd1,
    CMD_WRITE  = 3'd2,
    CMD_ERASE  = 3'd3,
    CMD_FILL   = 3'd4,
    CMD_WIPE   = 3'd5,
    CMD_ARM    = 3'd6,
    CMD_DISARM = 3'd7
  } cmd_e;

  // strobes from control to the edge-count datapath
  typedef struct packed {
    logic clrWindow;
    logic markStart;
    logic bumpCount;
  } dpStrobe_t;

  function automatic logic isWriteClass(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_FILL) || (c == CMD_WIPE);
  endfunction

  function automatic logic isLongForm(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_FILL);
  endfunction

endpackage

// File: rtl/wel_count_path.sv
module wel_count_path
  import wel_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIn,
  input  dpStrobe_t        strobe,
  output logic             csFall,
  output logic             started,
  output logic [CNT_W-1:0] edgeCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             csQ;
  logic             startedQ;
  logic [CNT_W-1:0] countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ      <= 1'b0;
      startedQ <= 1'b0;
      countQ   <= '0;
    end else begin
      csQ <= csIn;
      if (strobe.clrWindow) begin
        startedQ <= 1'b0;
        countQ   <= '0;
      end else begin
        if (strobe.markStart) startedQ <= 1'b1;
        if (strobe.bumpCount && (countQ != CNT_MAX)) countQ <= countQ + 1'b1;
      end
    end
  end

  assign csFall    = csQ & ~csIn;
  assign started   = startedQ;
  assign edgeCount = countQ;

  // R6: no edge is on the count before a start bit has been seen
  p_count_after_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (countQ != '0) |-> startedQ);

  // R10: a saturated counter stays put until the window clears
  p_count_saturates_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((countQ == CNT_MAX) && !strobe.clrWindow) |=> (countQ == CNT_MAX));

endmodule

// File: rtl/wel_decide_ctrl.sv
module wel_decide_ctrl
  import wel_pkg::*;
#(
  parameter int LONG_LEN  = 29,
  parameter int SHORT_LEN = 13,
  parameter int CTL_LEN   = 13,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csIn,
  input  logic             skRise,
  input  logic             diIn,
  input  cmd_e             cmdIn,
  input  logic             lowSupply,
  input  logic             csFall,
  input  logic             started,
  input  logic [CNT_W-1:0] edgeCount,
  output dpStrobe_t        strobe,
  output logic             commitWrite,
  output logic             cancelWrite,
  output logic             writeEnabled
);

  localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LEN);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);
  localparam logic [CNT_W-1:0] CTL_C   = CNT_W'(CTL_LEN);

  logic latchQ;
  logic poisonQ;
  logic commitQ;
  logic cancelQ;

  logic blocked;
  logic lenOk;
  logic goWrite;
  logic dropWrite;
  logic ctlOk;

  always_comb begin
    strobe.clrWindow = ~csIn;
    strobe.markStart = csIn & skRise & ~started & diIn;
    strobe.bumpCount = csIn & skRise & (started | diIn);
  end

  always_comb begin
    blocked   = poisonQ | lowSupply;
    lenOk     = isLongForm(cmdIn) ? (edgeCount == LONG_C) : (edgeCount == SHORT_C);
    goWrite   = csFall & isWriteClass(cmdIn) & latchQ & ~blocked & lenOk;
    dropWrite = csFall & isWriteClass(cmdIn) & ~goWrite;
    ctlOk     = csFall & ~blocked & (edgeCount >= CTL_C);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ  <= 1'b0;
      poisonQ <= 1'b0;
      commitQ <= 1'b0;
      cancelQ <= 1'b0;
    end else begin
      commitQ <= goWrite;
      cancelQ <= dropWrite;
      if (lowSupply) begin
        latchQ <= 1'b0;
      end else if (ctlOk && (cmdIn == CMD_ARM)) begin
        latchQ <= 1'b1;
      end else if (ctlOk && (cmdIn == CMD_DISARM)) begin
        latchQ <= 1'b0;
      end
      if (lowSupply)  poisonQ <= 1'b1;
      else if (!csIn) poisonQ <= 1'b0;
    end
  end

  assign commitWrite  = commitQ;
  assign cancelWrite  = cancelQ;
  assign writeEnabled = latchQ;

  // R1: a commit always saw an armed latch
  p_commit_needs_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
    commitQ |-> $past(latchQ));

  // R2: the latch only rises at the end of a frame
  p_arm_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchQ) |-> $past(csFall));

  // R4: long-form commits need the exact long count
  p_long_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (commitQ && isLongForm($past(cmdIn))) |-> ($past(edgeCount) == LONG_C));

  // R5: short-form commits need the exact short count
  p_short_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (commitQ && !isLongForm($past(cmdIn))) |-> ($past(edgeCount) == SHORT_C));

  // R7: low supply disarms by the next cycle
  p_low_disarms_r7: assert property (@(posedge clk) disable iff (!rstN)
    lowSupply |=> !latchQ);

  // R10: one verdict only, taken at chip-select fall
  p_one_verdict_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(commitQ && cancelQ));

  p_verdict_on_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    (commitQ || cancelQ) |-> $past(csFall));

endmodule

// File: rtl/wel_guard.sv
module wel_guard
  import wel_pkg::*;
#(
  parameter int LONG_LEN  = 29,
  parameter int SHORT_LEN = 13,
  parameter int CTL_LEN   = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csIn,
  input  logic       skRise,
  input  logic       diIn,
  input  logic [2:0] cmdIn,
  input  logic       lowSupply,
  output logic       commitWrite,
  output logic       cancelWrite,
  output logic       writeEnabled
);

  localparam int CNT_W = $clog2(LONG_LEN + 3);

  dpStrobe_t        strobe;
  logic             csFall;
  logic             started;
  logic [CNT_W-1:0] edgeCount;

  wel_count_path #(.CNT_W(CNT_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .csIn      (csIn),
    .strobe    (strobe),
    .csFall    (csFall),
    .started   (started),
    .edgeCount (edgeCount)
  );

  wel_decide_ctrl #(
    .LONG_LEN  (LONG_LEN),
    .SHORT_LEN (SHORT_LEN),
    .CTL_LEN   (CTL_LEN),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .csIn         (csIn),
    .skRise       (skRise),
    .diIn         (diIn),
    .cmdIn        (cmd_e'(cmdIn)),
    .lowSupply    (lowSupply),
    .csFall       (csFall),
    .started      (started),
    .edgeCount    (edgeCount),
    .strobe       (strobe),
    .commitWrite  (commitWrite),
    .cancelWrite  (cancelWrite),
    .writeEnabled (writeEnabled)
  );

endmodule

// File: tb/wel_guard_test.sv
module wel_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csIn = 1'b0;
  logic       skRise = 1'b0;
  logic       diIn = 1'b0;
  logic [2:0] cmdIn = 3'd0;
  logic       lowSupply = 1'b0;
  logic       commitWrite;
  logic       cancelWrite;
  logic       writeEnabled;

  int errors = 0;
  int checks = 0;
  int nCommit = 0;
  int nCancel = 0;
  bit finished = 0;
  string curReq = "R1";

  // reference model state
  int  mEdges = 0;
  bit  mStarted = 0;
  bit  mCsPrev = 0;
  bit  mLatch = 0;
  bit  mPoison = 0;
  bit  mCommit = 0;
  bit  mCancel = 0;

  wel_guard uut (
    .clk          (clk),
    .rstN         (rstN),
    .csIn         (csIn),
    .skRise       (skRise),
    .diIn         (diIn),
    .cmdIn        (cmdIn),
    .lowSupply    (lowSupply),
    .commitWrite  (commitWrite),
    .cancelWrite  (cancelWrite),
    .writeEnabled (writeEnabled)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit isWr(logic [2:0] k);
    return (k >= 3'd2) && (k <= 3'd5);
  endfunction

  function automatic int needLen(logic [2:0] k);
    return ((k == 3'd2) || (k == 3'd4)) ? 29 : 13;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mEdges = 0; mStarted = 0; mCsPrev = 0; mLatch = 0;
      mPoison = 0; mCommit = 0; mCancel = 0;
    end else begin
      bit fall;
      bit blk;
      fall = mCsPrev && !csIn;
      blk = mPoison || lowSupply;
      mCommit = 0;
      mCancel = 0;
      if (fall && isWr(cmdIn)) begin
        if (mLatch && !blk && (mEdges == needLen(cmdIn))) mCommit = 1;
        else mCancel = 1;
      end
      if (lowSupply) mLatch = 0;
      else if (fall && !blk && mEdges >= 13 && cmdIn == 3'd6) mLatch = 1;
      else if (fall && !blk && mEdges >= 13 && cmdIn == 3'd7) mLatch = 0;
      if (lowSupply) mPoison = 1;
      else if (!csIn) mPoison = 0;
      if (!csIn) begin
        mEdges = 0; mStarted = 0;
      end else if (skRise && (mStarted || diIn)) begin
        mEdges = mEdges + 1; mStarted = 1;
      end
      mCsPrev = csIn;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(curReq, "commitWrite", int'(commitWrite), int'(mCommit));
      check(curReq, "cancelWrite", int'(cancelWrite), int'(mCancel));
      check(curReq, "writeEnabled", int'(writeEnabled), int'(mLatch));
      if (commitWrite) nCommit++;
      if (cancelWrite) nCancel++;
    end
  end

  task automatic frame(input logic [2:0] k, input int edges, input int dummies, input int lowAt);
    @(negedge clk);
    cmdIn = k;
    csIn = 1'b1;
    @(negedge clk);
    for (int d = 0; d < dummies; d++) begin
      skRise = 1'b1; diIn = 1'b0;
      @(negedge clk);
      skRise = 1'b0;
      @(negedge clk);
    end
    for (int e = 0; e < edges; e++) begin
      skRise = 1'b1;
      diIn = (e == 0) ? 1'b1 : e[0];
      lowSupply = (e == lowAt);
      @(negedge clk);
      skRise = 1'b0; diIn = 1'b0; lowSupply = 1'b0;
      @(negedge clk);
    end
    csIn = 1'b0;
    repeat (3) @(negedge clk);
    cmdIn = 3'd0;
  endtask

  task automatic expectPulses(input string req, input int c0, input int x0, input int dc, input int dx);
    check(req, "commit pulses", nCommit - c0, dc);
    check(req, "cancel pulses", nCancel - x0, dx);
  endtask

  initial begin
    int c0;
    int x0;
    repeat (3) @(negedge clk);
    check("R1", "reset writeEnabled", int'(writeEnabled), 0);
    check("R1", "reset commitWrite", int'(commitWrite), 0);
    rstN = 1'b1;
    @(negedge clk);

    curReq = "R1"; c0 = nCommit; x0 = nCancel;
    frame(3'd2, 29, 0, -1);
    expectPulses("R1", c0, x0, 0, 1);

    curReq = "R3";
    frame(3'd6, 12, 0, -1);
    check("R3", "latch after short arm", int'(writeEnabled), 0);

    curReq = "R2";
    frame(3'd6, 13, 3, -1);
    check("R2", "latch after arm", int'(writeEnabled), 1);

    curReq = "R4"; c0 = nCommit; x0 = nCancel;
    frame(3'd2, 29, 0, -1);
    frame(3'd2, 28, 0, -1);
    frame(3'd2, 30, 0, -1);
    frame(3'd4, 29, 0, -1);
    expectPulses("R4", c0, x0, 2, 2);

    curReq = "R10"; c0 = nCommit; x0 = nCancel;
    frame(3'd4, 61, 0, -1);
    expectPulses("R10", c0, x0, 0, 1);

    curReq = "R5"; c0 = nCommit; x0 = nCancel;
    frame(3'd3, 13, 0, -1);
    frame(3'd3, 14, 0, -1);
    frame(3'd5, 12, 0, -1);
    frame(3'd5, 13, 0, -1);
    expectPulses("R5", c0, x0, 2, 2);

    curReq = "R6"; c0 = nCommit; x0 = nCancel;
    for (int s = 0; s < 4; s++) begin
      skRise = 1'b1; diIn = 1'b1;
      @(negedge clk);
      skRise = 1'b0; diIn = 1'b0;
      @(negedge clk);
    end
    frame(3'd3, 13, 5, -1);
    expectPulses("R6", c0, x0, 1, 0);

    curReq = "R9"; c0 = nCommit; x0 = nCancel;
    frame(3'd1, 29, 0, -1);
    frame(3'd0, 13, 0, -1);
    expectPulses("R9", c0, x0, 0, 0);
    check("R9", "latch after read", int'(writeEnabled), 1);

    curReq = "R2"; c0 = nCommit; x0 = nCancel;
    frame(3'd7, 13, 0, -1);
    check("R2", "latch after disarm", int'(writeEnabled), 0);
    frame(3'd3, 13, 0, -1);
    expectPulses("R2", c0, x0, 0, 1);

    curReq = "R7";
    frame(3'd6, 13, 0, -1);
    check("R7", "armed before low", int'(writeEnabled), 1);
    c0 = nCommit; x0 = nCancel;
    frame(3'd2, 29, 0, 10);
    expectPulses("R7", c0, x0, 0, 1);
    check("R7", "latch after low", int'(writeEnabled), 0);

    curReq = "R8"; c0 = nCommit; x0 = nCancel;
    frame(3'd3, 13, 0, -1);
    frame(3'd6, 13, 0, -1);
    frame(3'd3, 13, 0, -1);
    expectPulses("R8", c0, x0, 1, 1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule